// File: doc/BRIEF.md
# Virtual Count and Event Stream Generator

This block turns a free-running physical time count into a virtual time count. It subtracts a 64-bit offset that software programs from the physical count, and it registers the result. Only the low part of the physical count is implemented. Bits above that width are treated as zero, and the difference wraps modulo 2^64.

From the virtual count it also derives an event stream. Software picks one of the sixteen low bits of the virtual count and a transition direction. The block then emits a single-cycle pulse each time that bit makes the chosen transition, provided events are enabled. A change of the selected bit or of the direction takes effect without a false pulse. This lets software retune the event rate on the fly. A timer that consumes the count, or a core that waits on the events, connects directly to the outputs.

Top module: `vcnt_event_top`

## Requirements
- R1: `virt_cnt_o` equals the physical count minus `virt_off_i`, as sampled at the previous rising clock edge (one register stage).
- R2: The subtraction wraps modulo 2^64; an offset larger than the physical count yields 2^64 plus the negative difference.
- R3: Physical count bits 63 down to 56 are not implemented and are taken as zero, whatever value the input carries.
- R4: While `evt_en_i` is 0, `evt_pulse_o` stays 0 in the following cycle, whatever the count does.
- R5: With `evt_dir_i` = 0, a pulse follows each 0-to-1 transition of the selected virtual count bit.
- R6: With `evt_dir_i` = 1, a pulse follows each 1-to-0 transition of the selected virtual count bit.
- R7: `evt_sel_i` is a 4-bit unsigned index that selects virtual count bit 0 to 15; the value 15 selects bit 15.
- R8: A pulse is one cycle wide. It rises at the clock edge after the one that loaded the transitioned count value into `virt_cnt_o`.
- R9: No pulse is produced at an edge where `evt_sel_i` or `evt_dir_i` differs from its value at the previous edge. The transition history restarts from the newly selected bit.
- R10: While `rst` is high, `virt_cnt_o` and `evt_pulse_o` are 0 after each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phys_cnt_i | input | 64 | Physical time count; bits above 55 are ignored |
| virt_off_i | input | 64 | Virtual offset subtracted from the physical count |
| evt_en_i | input | 1 | Event generation enable |
| evt_dir_i | input | 1 | Edge select: 0 rising, 1 falling |
| evt_sel_i | input | 4 | Index of the virtual count bit that drives events |
| virt_cnt_o | output | 64 | Registered virtual count |
| evt_pulse_o | output | 1 | Single-cycle event pulse |

## Verification
The hardest case to reach is a configuration change that lands exactly when the newly selected bit differs from the history the old bit left behind. A naive design pulses in that cycle. The stimulus counts the physical input by one each cycle and rotates the bit index and the direction every few cycles, so many changes meet a mismatched history. Other phases push large offsets to force wrap-around, fill the unimplemented upper bits with random values, and step the count by 0x1000 so that the top selectable bit toggles.

// File: rtl/vcnt_pkg.sv
package vcnt_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_dir_e;

  localparam int CNT_W_DEF  = 64;
  localparam int PHYS_W_DEF = 56;
  localparam int SEL_W_DEF  = 4;
endpackage

// File: rtl/vcnt_subtract.sv
module vcnt_subtract #(
  parameter int CNT_W  = 64,
  parameter int PHYS_W = 56
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] phys_i,
  input  logic [CNT_W-1:0] off_i,
  output logic [CNT_W-1:0] virt_o
);
  localparam int PAD_W = CNT_W - PHYS_W;

  logic [CNT_W-1:0] phys_m;
  logic [CNT_W-1:0] virt_q;

  generate
    if (PAD_W > 0) begin : g_pad
      assign phys_m = {{PAD_W{1'b0}}, phys_i[PHYS_W-1:0]};
    end else begin : g_full
      assign phys_m = phys_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) virt_q <= '0;
    else     virt_q <= phys_m - off_i;
  end

  assign virt_o = virt_q;

  // R1 / R2: sum of output and earlier offset recovers earlier physical count
  assert_virt_diff_R1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (virt_o + $past(off_i)) == $past(phys_m));

  generate
    if (PAD_W > 0) begin : g_chk
      // R3: upper input bits never reach the count
      assert_upper_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (virt_o + $past(off_i)) < (64'd1 << PHYS_W));
    end
  endgenerate
endmodule

// File: rtl/vcnt_bit_pick.sv
module vcnt_bit_pick #(
  parameter int CNT_W = 64,
  parameter int SEL_W = 4
) (
  input  logic [CNT_W-1:0] vec_i,
  input  logic [SEL_W-1:0] idx_i,
  output logic             bit_o
);
  localparam int NSEL = 1 << SEL_W;

  logic [NSEL-1:0] taps;

  generate
    for (genvar g = 0; g < NSEL; g++) begin : g_tap
      if (g < CNT_W) begin : g_real
        assign taps[g] = vec_i[g];
      end else begin : g_none
        assign taps[g] = 1'b0;
      end
    end
  endgenerate

  assign bit_o = taps[idx_i];
endmodule

// File: rtl/vcnt_edge_det.sv
module vcnt_edge_det
  import vcnt_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  edge_dir_e        dir_i,
  input  logic [SEL_W-1:0] idx_i,
  input  logic             bit_i,
  output logic             evt_o
);
  localparam int CFG_W = SEL_W + 1;

  logic             prev_q;
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_now;
  logic             cfg_same;
  logic             hit;
  logic             evt_q;

  assign cfg_now  = {idx_i, dir_i};
  assign cfg_same = (cfg_now == cfg_q);

  always_comb begin
    unique case (dir_i)
      EDGE_RISE: hit = ~prev_q &  bit_i;
      EDGE_FALL: hit =  prev_q & ~bit_i;
      default:   hit = 1'b0;
    endcase
  end

  // history and configuration track every cycle, reset included
  always_ff @(posedge clk) begin
    prev_q <= bit_i;
    cfg_q  <= cfg_now;
  end

  always_ff @(posedge clk) begin
    if (rst) evt_q <= 1'b0;
    else     evt_q <= en_i & cfg_same & hit;
  end

  assign evt_o = evt_q;

  assert_evt_gated_R4: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !evt_o);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    evt_o |=> !evt_o);

  assert_no_evt_on_cfg_change_R9: assert property (@(posedge clk) disable iff (rst)
    (idx_i != $past(idx_i) || dir_i != $past(dir_i)) |=> !evt_o);

  assert_rise_needs_high_R5: assert property (@(posedge clk) disable iff (rst)
    (en_i && dir_i == EDGE_RISE && !bit_i) |=> !evt_o);
endmodule

// File: rtl/vcnt_event_top.sv
module vcnt_event_top
  import vcnt_pkg::*;
#(
  parameter int CNT_W  = CNT_W_DEF,
  parameter int PHYS_W = PHYS_W_DEF,
  parameter int SEL_W  = SEL_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [63:0]      phys_cnt_i,
  input  logic [63:0]      virt_off_i,
  input  logic             evt_en_i,
  input  logic             evt_dir_i,
  input  logic [3:0]       evt_sel_i,
  output logic [63:0]      virt_cnt_o,
  output logic             evt_pulse_o
);
  logic [CNT_W-1:0] virt_w;
  logic             sel_bit;
  edge_dir_e        dir_e;

  assign dir_e = edge_dir_e'(evt_dir_i);

  vcnt_subtract #(.CNT_W(CNT_W), .PHYS_W(PHYS_W)) u_sub (
    .clk    (clk),
    .rst    (rst),
    .phys_i (phys_cnt_i[CNT_W-1:0]),
    .off_i  (virt_off_i[CNT_W-1:0]),
    .virt_o (virt_w)
  );

  vcnt_bit_pick #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_pick (
    .vec_i (virt_w),
    .idx_i (evt_sel_i[SEL_W-1:0]),
    .bit_o (sel_bit)
  );

  vcnt_edge_det #(.SEL_W(SEL_W)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .en_i  (evt_en_i),
    .dir_i (dir_e),
    .idx_i (evt_sel_i[SEL_W-1:0]),
    .bit_i (sel_bit),
    .evt_o (evt_pulse_o)
  );

  assign virt_cnt_o = virt_w;

  // R10: reset clears both outputs by the next edge
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (virt_cnt_o == '0 && !evt_pulse_o));
endmodule

// File: tb/sim_vcnt_event_top.sv
module sim_vcnt_event_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] PHYS_MASK = (64'd1 << 56) - 64'd1;

  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] phys_cnt_i;
  logic [63:0] virt_off_i;
  logic        evt_en_i;
  logic        evt_dir_i;
  logic [3:0]  evt_sel_i;
  logic [63:0] virt_cnt_o;
  logic        evt_pulse_o;

  int n_checks = 0;
  int n_fails  = 0;
  string vtag = "R10";
  string etag = "R10";

  // behavioural model state
  logic [63:0] hist[$];
  int          last_sel = -1;
  int          last_dir = -1;
  logic [63:0] exp_virt = '0;
  logic        exp_evt  = 1'b0;

  vcnt_event_top u0 (
    .clk(clk), .rst(rst), .phys_cnt_i(phys_cnt_i), .virt_off_i(virt_off_i),
    .evt_en_i(evt_en_i), .evt_dir_i(evt_dir_i), .evt_sel_i(evt_sel_i),
    .virt_cnt_o(virt_cnt_o), .evt_pulse_o(evt_pulse_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  endtask

  task automatic model_edge();
    int s;
    int d;
    logic cur_b;
    logic old_b;
    s = int'(evt_sel_i);
    d = int'(evt_dir_i);
    if (rst) begin
      exp_evt = 1'b0;
      hist.delete();
      hist.push_back(64'd0);
      exp_virt = 64'd0;
    end else begin
      cur_b = exp_virt[s];
      old_b = (hist.size() > 1) ? hist[hist.size()-2][s] : 1'b0;
      exp_evt = evt_en_i && (s == last_sel) && (d == last_dir) &&
                ((d == 0) ? (!old_b && cur_b) : (old_b && !cur_b));
      exp_virt = (phys_cnt_i & PHYS_MASK) - virt_off_i;
      hist.push_back(exp_virt);
      if (hist.size() > 4) void'(hist.pop_front());
    end
    last_sel = s;
    last_dir = d;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    n_checks++;
    if (virt_cnt_o !== exp_virt) begin
      n_fails++;
      $display("FAIL %s virt_cnt_o actual=%h expected=%h", vtag, virt_cnt_o, exp_virt);
    end
    n_checks++;
    if (evt_pulse_o !== exp_evt) begin
      n_fails++;
      $display("FAIL %s evt_pulse_o actual=%b expected=%b", etag, evt_pulse_o, exp_evt);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; phys_cnt_i = 64'h1234; virt_off_i = 64'h10;
    evt_en_i = 1'b1; evt_dir_i = 1'b0; evt_sel_i = 4'd0;
    @(negedge clk);
    // R10: outputs cleared during reset
    vtag = "R10"; etag = "R10";
    repeat (4) step();
    rst = 1'b0;

    // R1 with R4: counting, events disabled
    vtag = "R1"; etag = "R4";
    evt_en_i = 1'b0; phys_cnt_i = 64'd1000; virt_off_i = 64'd37;
    for (int i = 0; i < 60; i++) begin
      step();
      phys_cnt_i = phys_cnt_i + 64'd1;
    end

    // R2: offset larger than physical count
    vtag = "R2";
    virt_off_i = 64'hFFFF_0000_0000_0005;
    for (int i = 0; i < 20; i++) begin
      step();
      phys_cnt_i = phys_cnt_i + 64'd3;
    end

    // R3: garbage in unimplemented bits
    vtag = "R3";
    for (int i = 0; i < 40; i++) begin
      phys_cnt_i = {$urandom, $urandom};
      virt_off_i = (i % 2 == 0) ? 64'd0 : {$urandom, $urandom};
      step();
    end

    // R5: rising edges, bit 2
    vtag = "R1"; etag = "R5";
    phys_cnt_i = 64'd0; virt_off_i = 64'd0;
    evt_en_i = 1'b1; evt_dir_i = 1'b0; evt_sel_i = 4'd2;
    for (int i = 0; i < 80; i++) begin
      step();
      phys_cnt_i = phys_cnt_i + 64'd1;
    end

    // R6: falling edges, bit 0, with an offset
    etag = "R6";
    evt_dir_i = 1'b1; evt_sel_i = 4'd0; virt_off_i = 64'd5;
    for (int i = 0; i < 60; i++) begin
      step();
      phys_cnt_i = phys_cnt_i + 64'd1;
    end

    // R7: top selectable bit 15
    etag = "R7";
    evt_dir_i = 1'b0; evt_sel_i = 4'd15; virt_off_i = 64'd0; phys_cnt_i = 64'd0;
    for (int i = 0; i < 80; i++) begin
      step();
      phys_cnt_i = phys_cnt_i + 64'h1000;
    end

    // R8: bit 0 rising, pulses every other cycle, each one cycle wide
    etag = "R8";
    evt_sel_i = 4'd0; evt_dir_i = 1'b0;
    for (int i = 0; i < 40; i++) begin
      step();
      phys_cnt_i = phys_cnt_i + 64'd1;
    end

    // R9: rotate index and direction while counting
    etag = "R9";
    for (int i = 0; i < 300; i++) begin
      if (i % 3 == 0) evt_sel_i = 4'((i / 3) % 4);
      if (i % 7 == 0) evt_dir_i = ~evt_dir_i;
      step();
      phys_cnt_i = phys_cnt_i + 64'd1;
    end

    // R4 again: disable mid-stream
    etag = "R4";
    evt_en_i = 1'b0; evt_sel_i = 4'd1;
    for (int i = 0; i < 40; i++) begin
      step();
      phys_cnt_i = phys_cnt_i + 64'd1;
    end

    // mixed random traffic
    vtag = "R1"; etag = "R5";
    for (int i = 0; i < 400; i++) begin
      evt_en_i = ($urandom % 8) != 0;
      if ($urandom % 10 == 0) evt_sel_i = 4'($urandom);
      if ($urandom % 13 == 0) evt_dir_i = 1'($urandom);
      if ($urandom % 50 == 0) virt_off_i = {$urandom, $urandom};
      phys_cnt_i = phys_cnt_i + 64'($urandom % 5);
      step();
    end

    // R10: reset again mid-run
    vtag = "R10"; etag = "R10";
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    vtag = "R1"; etag = "R5";
    repeat (10) step();

    finish_run();
  end
endmodule